// File: doc/BRIEF.md
# Flash Program and Erase Command Front-End

This block sits between a simple register bus and an embedded flash array. Software loads a target address, a data word and a clock divider. It then writes a control word that carries an unlock key, an erase code and one or more command bits. The block checks the request. If the request is valid, it runs one program, page-erase or mass-erase operation for a fixed number of timebase ticks. The timebase is the system clock divided by the programmed divider, which nominally gives a 1 MHz tick. While the operation runs, the block drives one level-held select line toward the array.

Completion and refused requests are recorded as two interrupt flags, each with its own enable, and the enabled flags are ORed onto one interrupt line. While an operation is in progress the register file is frozen: only the interrupt register accepts writes, and a command written in that window is refused and flagged. The bus is a plain strobe interface. Writes take effect at the clock edge that samples them, and a read returns its data on the cycle after the read strobe. The bus has no back-pressure and never stalls.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, the divider register reads 0x64, the control register reads 0x3000_0000 (key field = 3, locked), the interrupt register reads 0, and the busy, irq and all select outputs are low.
- R2: Registers are decoded at offsets 0x00 (address, 32 bits), 0x04 (divider, bits 7:0 only, upper bits read 0), 0x08 (control), 0x24 (interrupt) and 0x30 (data, 32 bits). Read data appears on bus_rdata one cycle after the read strobe. The address and data registers drive flash_addr and flash_data.
- R3: A control write with bit 0 set and key field bits 31:28 equal to 2 starts a program operation one cycle after the write. busy, control bit 24 and flash_prog stay high for PROG_TICKS × divider cycles. The command bits read 0 afterwards.
- R4: A page erase (bit 2) starts only with erase code bits 15:8 equal to 0x55. A mass erase (bit 1) starts only with code 0xAA and dbg_en high. The erase code reads 0 after the operation.
- R5: A request that is refused (key not 2, wrong erase code, or mass erase without dbg_en) starts nothing. On the next cycle it clears the command bits and the erase code and sets interrupt bit 1 (access fail).
- R6: While busy is high, writes to the address, data, divider and control registers have no effect. Writes to the interrupt register still take effect.
- R7: A control write that carries any command bit while an operation is in progress sets interrupt bit 1.
- R8: Interrupt bit 0 (done) is set when an operation ends. If a software clear of the flag falls on the same edge, the hardware set wins.
- R9: Writing 0 to bit 0 or bit 1 of the interrupt register clears that flag, and writing 1 leaves it unchanged. Bits 8 and 9 are the enables for done and access-fail. irq = (done AND bit 8) OR (access-fail AND bit 9).
- R10: When several command bits are set together, only one operation is considered, with priority mass erase, then page erase, then program. At most one select output is ever high.
- R11: A divider value of 0 acts as 1, so an operation then lasts exactly its tick count in cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_off | input | OFF_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| dbg_en | input | 1 | Debug access enabled; required for mass erase |
| irq | output | 1 | Enabled interrupt flags ORed |
| busy | output | 1 | Operation in progress |
| flash_addr | output | 32 | Target address register |
| flash_data | output | 32 | Program data register |
| flash_prog | output | 1 | Program operation active |
| flash_page_erase | output | 1 | Page erase active |
| flash_mass_erase | output | 1 | Mass erase active |

## Verification
An operation that ends and a software write that clears the done flag can land on the same clock edge. The bench first measures how long a program operation runs at the chosen divider. It then starts another program operation and times an interrupt-register write of zero so that the write is sampled on the edge where busy falls. The case is judged by reading the interrupt register afterwards: done must read 1, because the hardware set wins over the software clear. A second overlap, a command write that arrives while busy, is provoked inside a page erase and judged by the access-fail flag and the unchanged control field.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFF_ADDR = 8'h00;
  localparam logic [7:0] OFF_DIV  = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_INTR = 8'h24;
  localparam logic [7:0] OFF_DATA = 8'h30;

  localparam logic [3:0] KEY_OPEN = 4'h2;
  localparam logic [3:0] KEY_SHUT = 4'h3;
  localparam logic [7:0] CODE_PAGE = 8'h55;
  localparam logic [7:0] CODE_MASS = 8'hAA;

  // control field positions
  localparam int unsigned CB_PROG = 0;
  localparam int unsigned CB_MASS = 1;
  localparam int unsigned CB_PAGE = 2;
  localparam int unsigned CB_BUSY = 24;

  // interrupt field positions
  localparam int unsigned IB_DONE   = 0;
  localparam int unsigned IB_FAIL   = 1;
  localparam int unsigned IB_DONEIE = 8;
  localparam int unsigned IB_FAILIE = 9;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_PAGE, OP_MASS} op_e;
endpackage

// File: rtl/flc_tick_div.sv
module flc_tick_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  // a divider of zero behaves as one
  assign last = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/flc_op_seq.sv
module flc_op_seq
  import flc_pkg::*;
#(
  parameter int unsigned PROG_TICKS = 3,
  parameter int unsigned PAGE_TICKS = 5,
  parameter int unsigned MASS_TICKS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  input  logic [3:0] key,
  input  logic [7:0] code,
  input  logic       dbg_en,
  input  logic       tick,
  output logic       busy,
  output op_e        op,
  output logic       start,
  output logic       finish,
  output logic       reject
);
  localparam int unsigned MAX_PE = (PROG_TICKS > PAGE_TICKS) ? PROG_TICKS : PAGE_TICKS;
  localparam int unsigned MAX_T  = (MAX_PE > MASS_TICKS) ? MAX_PE : MASS_TICKS;
  localparam int unsigned TW     = (MAX_T < 2) ? 1 : $clog2(MAX_T + 1);

  logic          pending;
  op_e           sel;
  logic          ok;
  logic [TW-1:0] len;
  logic [TW-1:0] tcnt;

  assign pending = (|cmd) && !busy;

  always_comb begin
    if (cmd[CB_MASS])      sel = OP_MASS;
    else if (cmd[CB_PAGE]) sel = OP_PAGE;
    else if (cmd[CB_PROG]) sel = OP_PROG;
    else                   sel = OP_NONE;
  end

  always_comb begin
    ok = 1'b0;
    if (key == KEY_OPEN) begin
      unique case (sel)
        OP_PROG: ok = 1'b1;
        OP_PAGE: ok = (code == CODE_PAGE);
        OP_MASS: ok = (code == CODE_MASS) && dbg_en;
        default: ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (op)
      OP_PAGE: len = TW'(PAGE_TICKS);
      OP_MASS: len = TW'(MASS_TICKS);
      default: len = TW'(PROG_TICKS);
    endcase
  end

  assign start  = pending && ok;
  assign reject = pending && !ok;
  assign finish = busy && tick && (tcnt == len - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op   <= OP_NONE;
      tcnt <= '0;
    end else if (start) begin
      busy <= 1'b1;
      op   <= sel;
      tcnt <= '0;
    end else if (finish) begin
      busy <= 1'b0;
      op   <= OP_NONE;
      tcnt <= '0;
    end else if (busy && tick) begin
      tcnt <= tcnt + TW'(1);
    end
  end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flc_pkg::*;
#(
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned DIV_W      = 8,
  parameter logic [7:0]  DIV_RST    = 8'h64,
  parameter int unsigned PROG_TICKS = 3,
  parameter int unsigned PAGE_TICKS = 5,
  parameter int unsigned MASS_TICKS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [OFF_W-1:0] bus_off,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             dbg_en,
  output logic             irq,
  output logic             busy,
  output logic [31:0]      flash_addr,
  output logic [31:0]      flash_data,
  output logic             flash_prog,
  output logic             flash_page_erase,
  output logic             flash_mass_erase
);
  logic [31:0]      addr_q, data_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       key_q;
  logic [7:0]       code_q;
  logic [2:0]       cmd_q;
  logic             done_q, fail_q, done_ie, fail_ie;

  logic tick, start, finish, reject;
  op_e  op;

  flc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  flc_op_seq #(
    .PROG_TICKS(PROG_TICKS), .PAGE_TICKS(PAGE_TICKS), .MASS_TICKS(MASS_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .key(key_q), .code(code_q),
    .dbg_en(dbg_en), .tick(tick), .busy(busy), .op(op),
    .start(start), .finish(finish), .reject(reject)
  );

  // decode
  logic blocked, hit_addr, hit_div, hit_ctrl, hit_intr, hit_data, late_cmd;
  assign blocked  = busy || (|cmd_q);
  assign hit_addr = bus_wr && (bus_off == OFF_W'(OFF_ADDR));
  assign hit_div  = bus_wr && (bus_off == OFF_W'(OFF_DIV));
  assign hit_ctrl = bus_wr && (bus_off == OFF_W'(OFF_CTRL));
  assign hit_intr = bus_wr && (bus_off == OFF_W'(OFF_INTR));
  assign hit_data = bus_wr && (bus_off == OFF_W'(OFF_DATA));
  assign late_cmd = hit_ctrl && blocked && (|bus_wdata[2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
    end else if (!blocked) begin
      if (hit_addr) addr_q <= bus_wdata;
      if (hit_data) data_q <= bus_wdata;
      if (hit_div)  div_q  <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= KEY_SHUT;
      code_q <= '0;
      cmd_q  <= '0;
    end else if (reject || finish) begin
      cmd_q  <= '0;
      code_q <= '0;
    end else if (hit_ctrl && !blocked) begin
      key_q  <= bus_wdata[31:28];
      code_q <= bus_wdata[15:8];
      cmd_q  <= bus_wdata[2:0];
    end
  end

  // hardware sets take precedence over software clears
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      done_ie <= 1'b0;
      fail_ie <= 1'b0;
    end else begin
      if (finish)        done_q <= 1'b1;
      else if (hit_intr) done_q <= done_q & bus_wdata[IB_DONE];
      if (reject || late_cmd) fail_q <= 1'b1;
      else if (hit_intr)      fail_q <= fail_q & bus_wdata[IB_FAIL];
      if (hit_intr) begin
        done_ie <= bus_wdata[IB_DONEIE];
        fail_ie <= bus_wdata[IB_FAILIE];
      end
    end
  end

  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    if (bus_off == OFF_W'(OFF_ADDR)) rmux = addr_q;
    else if (bus_off == OFF_W'(OFF_DATA)) rmux = data_q;
    else if (bus_off == OFF_W'(OFF_DIV)) rmux[DIV_W-1:0] = div_q;
    else if (bus_off == OFF_W'(OFF_CTRL)) begin
      rmux[31:28]   = key_q;
      rmux[CB_BUSY] = busy;
      rmux[15:8]    = code_q;
      rmux[2:0]     = cmd_q;
    end else if (bus_off == OFF_W'(OFF_INTR)) begin
      rmux[IB_DONE]   = done_q;
      rmux[IB_FAIL]   = fail_q;
      rmux[IB_DONEIE] = done_ie;
      rmux[IB_FAILIE] = fail_ie;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rmux;
  end

  assign irq              = (done_q && done_ie) || (fail_q && fail_ie);
  assign flash_addr       = addr_q;
  assign flash_data       = data_q;
  assign flash_prog       = (op == OP_PROG);
  assign flash_page_erase = (op == OP_PAGE);
  assign flash_mass_erase = (op == OP_MASS);
endmodule

// File: rtl/flc_chk.sv
module flc_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             prog,
  input logic             page,
  input logic             mass,
  input logic             dbg_en,
  input logic [3:0]       key,
  input logic [31:0]      addr,
  input logic [DIV_W-1:0] div,
  input logic             done
);
  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog, page, mass}));                                  // R10
  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key) == 4'h2);                            // R3
  AST_MASS_NEEDS_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mass) |-> $past(dbg_en));                                 // R4
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(addr));                         // R6
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(div));                          // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                          // R8
  AST_SELECT_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog || page || mass) |-> busy);                               // R3
endmodule

bind flash_cmd_frontend flc_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .prog(flash_prog),
  .page(flash_page_erase), .mass(flash_mass_erase), .dbg_en(dbg_en),
  .key(key_q), .addr(addr_q), .div(div_q), .done(done_q)
);

// File: tb/sim_flash_cmd_frontend.sv
`timescale 1ns/1ps
module sim_flash_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, dbg_en = 1'b0;
  logic [7:0]  bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, flash_addr, flash_data;
  logic        irq, busy, flash_prog, flash_page_erase, flash_mass_erase;

  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  flash_cmd_frontend u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_en(dbg_en), .irq(irq), .busy(busy), .flash_addr(flash_addr),
    .flash_data(flash_data), .flash_prog(flash_prog),
    .flash_page_erase(flash_page_erase), .flash_mass_erase(flash_mass_erase)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underrun", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    bus_wr = 1'b1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_off = off;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // counts cycles with busy high; every busy cycle must show only sel_exp on the selects
  task automatic run_len(input logic [2:0] sel_exp, output int n, output int sel_bad);
    n = 0; sel_bad = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busy) begin
        n++;
        if ({flash_mass_erase, flash_page_erase, flash_prog} !== sel_exp) sel_bad++;
      end else if (n > 0) break;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, sb;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 selects", {29'd0, flash_mass_erase, flash_page_erase, flash_prog}, 32'd0);
    rd(8'h04, 32'h64, "R1 divider reset");
    rd(8'h08, 32'h3000_0000, "R1 control reset");
    rd(8'h24, 32'h0, "R1 interrupt reset");

    // R2 register map
    wr(8'h00, 32'h1234_5678);
    wr(8'h30, 32'hCAFE_F00D);
    wr(8'h04, 32'h0000_0102);
    rd(8'h00, 32'h1234_5678, "R2 address");
    rd(8'h30, 32'hCAFE_F00D, "R2 data");
    rd(8'h04, 32'h0000_0002, "R2 divider 8 bits");
    check("R2 flash_addr", flash_addr, 32'h1234_5678);
    check("R2 flash_data", flash_data, 32'hCAFE_F00D);

    // R5 locked program request
    wr(8'h08, 32'h3000_0001);
    check("R5 locked no busy", {31'd0, busy}, 32'd0);
    idle(1);
    rd(8'h08, 32'h3000_0000, "R5 locked cmd cleared");
    rd(8'h24, 32'h0000_0002, "R5 locked fail flag");

    // R9 clear by zero, one keeps
    wr(8'h24, 32'h0000_0000);
    rd(8'h24, 32'h0, "R9 clear by zero");
    wr(8'h24, 32'h0000_0003);
    rd(8'h24, 32'h0, "R9 one does not set");

    // R3 program
    wr(8'h08, 32'h2000_0001);
    run_len(3'b001, n, sb);
    check("R3 program length", n, 32'd6);
    check("R3 flash_prog only", sb, 32'd0);
    rd(8'h08, 32'h2000_0000, "R3 cmd self-cleared");
    rd(8'h24, 32'h0000_0001, "R8 done after program");
    wr(8'h24, 32'h0);

    // R4/R5 page erase wrong code
    wr(8'h08, 32'h2000_1104);
    idle(1);
    check("R5 wrong code no busy", {31'd0, busy}, 32'd0);
    rd(8'h08, 32'h2000_0000, "R5 wrong code cleared");
    rd(8'h24, 32'h0000_0002, "R5 wrong code fail");
    wr(8'h24, 32'h0);

    // R4 page erase with writes during busy (R6, R7)
    wr(8'h08, 32'h2000_5504);
    idle(1);
    check("R4 page select", {29'd0, flash_mass_erase, flash_page_erase, flash_prog}, 32'd2);
    rd(8'h08, 32'h2100_5504, "R3 busy bit readable");
    wr(8'h00, 32'hFFFF_0000);
    wr(8'h08, 32'h2000_0001);
    wr(8'h24, 32'h0000_0302);
    check("R9 irq from enabled fail", {31'd0, irq}, 32'd1);
    wait_idle();
    rd(8'h00, 32'h1234_5678, "R6 address ignored while busy");
    rd(8'h08, 32'h2000_0000, "R4 erase code cleared");
    rd(8'h24, 32'h0000_0303, "R7 fail on busy command");
    wr(8'h24, 32'h0000_0300);
    rd(8'h24, 32'h0000_0300, "R9 flags cleared enables kept");
    check("R9 irq low", {31'd0, irq}, 32'd0);

    // R4/R5 mass erase without debug
    wr(8'h08, 32'h2000_AA02);
    idle(1);
    check("R4 mass refused without debug", {31'd0, busy}, 32'd0);
    rd(8'h24, 32'h0000_0302, "R5 mass refused fail");
    check("R9 irq on fail", {31'd0, irq}, 32'd1);
    wr(8'h24, 32'h0);

    // R4 mass erase with debug
    dbg_en = 1'b1;
    wr(8'h08, 32'h2000_AA02);
    run_len(3'b100, n, sb);
    check("R4 mass length", n, 32'd14);
    check("R4 mass select only", sb, 32'd0);
    rd(8'h08, 32'h2000_0000, "R4 mass code cleared");
    wr(8'h24, 32'h0);

    // R10 priority: all three bits with mass code
    wr(8'h08, 32'h2000_AA07);
    run_len(3'b100, n, sb);
    check("R10 mass wins", sb, 32'd0);
    check("R10 mass length", n, 32'd14);
    rd(8'h08, 32'h2000_0000, "R10 all bits cleared");
    wr(8'h24, 32'h0);
    dbg_en = 1'b0;

    // R8 software clear on the finishing edge
    wr(8'h08, 32'h2000_0001);
    idle(6);
    check("R8 still busy before end", {31'd0, busy}, 32'd1);
    wr(8'h24, 32'h0);
    check("R8 busy fell", {31'd0, busy}, 32'd0);
    rd(8'h24, 32'h0000_0001, "R8 hardware set wins");
    wr(8'h24, 32'h0);

    // R11 divider zero
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0, "R11 divider zero stored");
    wr(8'h08, 32'h2000_0001);
    run_len(3'b001, n, sb);
    check("R11 divider zero length", n, 32'd3);

    idle(3);
    check("scoreboard drained", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule